// File: doc/BRIEF.md
# Register Redirection Lookup Table

This block keeps a small set of software-written configuration words. Each word names one architectural register and says how that register is treated. The register can be integer or floating-point, chosen by a type bit. For that register the word gives a replacement register number, a vector or scalar flag, an element-width code, a packed-SIMD flag and a bank bit. A register with no word marking it stays unchanged. Each word is written through a one-cycle write strobe that carries an entry number and a 16-bit value.

The written words are not searched at lookup time. Instead, the block rebuilds two registered 32-slot shadow tables from every valid word, one table for integer registers and one for floating-point registers. A lookup is then a single indexed read of the right table. Two independent lookup ports let the two source operands of one instruction be redirected in the same cycle. When a register matches no valid word, the lookup reports a miss and passes the original register number through. All attribute outputs are then zero.

Top module: `regredir_table`

## Requirements
- R1: After reset no lookup hits. Every port returns hit=0, index equal to the requested register number, and zero vector, width, packed and bank outputs.
- R2: The lookup key is bits 4..0 of a configuration word. A hit returns these fields of the word: bits 9..5 as the index, bit 13 as the vector flag, bits 12..11 as the width code, bit 15 as the packed flag and bit 14 as the bank bit.
- R3: Bit 10 of a word selects its table: 0 for integer lookups (is_fp=0) and 1 for floating-point lookups (is_fp=1). A word never hits a lookup of the other type.
- R4: A lookup that matches no valid word returns hit=0 and the requested register number as the index, with vector, width, packed and bank outputs all zero.
- R5: When two valid words share a key and a type, the one with the higher entry number decides the lookup, regardless of the order in which they were written.
- R6: Overwriting an entry with a new key removes its old mapping. The old key then resolves to the next remaining word, or to a miss.
- R7: A write strobe in cycle N does not change lookups in cycle N+1. From cycle N+2 on, lookups reflect the write.
- R8: Both lookup ports resolve independently in the same cycle. Each port can use its own register number and type.
- R9: Reset marks every entry invalid again. A mapping that hit before the reset misses after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one configuration word |
| cfg_sel | input | 4 | Entry number being written |
| cfg_word | input | 16 | Configuration word value |
| lk_reg | input | 10 | Register number for each port (5 bits per port, port 0 in the low bits) |
| lk_is_fp | input | 2 | Table select for each port, 1 = floating-point |
| lk_hit | output | 2 | Per-port hit flag |
| lk_idx | output | 10 | Per-port redirected register number |
| lk_vec | output | 2 | Per-port vector flag |
| lk_width | output | 4 | Per-port element-width code (2 bits per port) |
| lk_simd | output | 2 | Per-port packed flag |
| lk_bank | output | 2 | Per-port bank bit |

## Verification
A corrupted stored word or a stale shadow slot shows up as a wrong index or attribute on the very next lookup of that key once the two-cycle rebuild has passed. The bench therefore probes every key it has touched right after each update. A rebuild that leaves an old mapping in place, or that scans entries in the wrong order, shows up only when keys collide. Overwritten and duplicated keys are therefore read back on both tables and on both ports. A lookup in the cycle straight after a write checks that the shadow does not move early.

// File: rtl/regredir_pkg.sv
`timescale 1ns/1ps
package regredir_pkg;
   localparam int WORD_W = 16;
   localparam int REG_W  = 5;
   localparam int WID_W  = 2;

   // Configuration word, most significant field first.
   typedef struct packed {
      logic             simd;
      logic             bank;
      logic             is_vec;
      logic [WID_W-1:0] width;
      logic             is_fp;
      logic [REG_W-1:0] target;
      logic [REG_W-1:0] key;
   } cfg_word_t;

   // One shadow slot.
   typedef struct packed {
      logic             hit;
      logic             simd;
      logic             bank;
      logic             is_vec;
      logic [WID_W-1:0] width;
      logic [REG_W-1:0] target;
   } slot_t;

   function automatic slot_t slot_from_word(input cfg_word_t w);
      slot_t s;
      s.hit    = 1'b1;
      s.simd   = w.simd;
      s.bank   = w.bank;
      s.is_vec = w.is_vec;
      s.width  = w.width;
      s.target = w.target;
      return s;
   endfunction
endpackage

// File: rtl/regredir_cfg_store.sv
`timescale 1ns/1ps
module regredir_cfg_store
   import regredir_pkg::*;
#(
   parameter int N_ENT = 16,
   localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] sel,
   input  logic [WORD_W-1:0] wdata,
   output cfg_word_t        words [N_ENT],
   output logic [N_ENT-1:0] valid
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[g] <= '0;
            valid[g] <= 1'b0;
         end else if (we && (sel == SEL_W'(g))) begin
            words[g] <= cfg_word_t'(wdata);
            valid[g] <= 1'b1;
         end
      end
   end

   // R2: a strobe leaves the addressed entry valid and holding the word
   a_r2_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (valid[$past(sel)] && (words[$past(sel)] == cfg_word_t'($past(wdata)))));
endmodule

// File: rtl/regredir_shadow_build.sv
`timescale 1ns/1ps
module regredir_shadow_build
   import regredir_pkg::*;
#(
   parameter int N_ENT      = 16,
   parameter int N_REG      = 32,
   parameter bit LATER_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cfg_word_t        words [N_ENT],
   input  logic [N_ENT-1:0] valid,
   output slot_t            int_tab [N_REG],
   output slot_t            fp_tab  [N_REG]
);
   slot_t nxt_int [N_REG];
   slot_t nxt_fp  [N_REG];

   // The scan order decides which duplicate key survives: the entry
   // visited last overwrites the slot.
   if (LATER_WINS) begin : g_scan_up
      always_comb begin
         for (int r = 0; r < N_REG; r++) begin
            nxt_int[r] = '0;
            nxt_fp[r]  = '0;
         end
         for (int k = 0; k < N_ENT; k++) begin
            if (valid[k]) begin
               if (words[k].is_fp) nxt_fp[words[k].key]  = slot_from_word(words[k]);
               else                nxt_int[words[k].key] = slot_from_word(words[k]);
            end
         end
      end
   end else begin : g_scan_down
      always_comb begin
         for (int r = 0; r < N_REG; r++) begin
            nxt_int[r] = '0;
            nxt_fp[r]  = '0;
         end
         for (int k = N_ENT - 1; k >= 0; k--) begin
            if (valid[k]) begin
               if (words[k].is_fp) nxt_fp[words[k].key]  = slot_from_word(words[k]);
               else                nxt_int[words[k].key] = slot_from_word(words[k]);
            end
         end
      end
   end

   for (genvar r = 0; r < N_REG; r++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            int_tab[r] <= '0;
            fp_tab[r]  <= '0;
         end else begin
            int_tab[r] <= nxt_int[r];
            fp_tab[r]  <= nxt_fp[r];
         end
      end
   end

   logic [N_REG-1:0] int_hits, fp_hits;
   always_comb begin
      for (int r = 0; r < N_REG; r++) begin
         int_hits[r] = int_tab[r].hit;
         fp_hits[r]  = fp_tab[r].hit;
      end
   end

   // R1/R9: with no valid entry, the next rebuild holds no hit
   a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (valid == '0) |=> ((int_hits == '0) && (fp_hits == '0)));

   // R5: duplicate keys collapse; hits never outnumber the valid entries
   a_r5_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(int_hits) + $countones(fp_hits)) <= $countones($past(valid)));
endmodule

// File: rtl/regredir_lookup_port.sv
`timescale 1ns/1ps
module regredir_lookup_port
   import regredir_pkg::*;
#(
   parameter int N_REG = 32
) (
   input  logic [REG_W-1:0] reg_no,
   input  logic             is_fp,
   input  slot_t            int_tab [N_REG],
   input  slot_t            fp_tab  [N_REG],
   output logic             hit,
   output logic [REG_W-1:0] idx,
   output logic             is_vec,
   output logic [WID_W-1:0] width,
   output logic             simd,
   output logic             bank
);
   slot_t s;
   always_comb begin
      s      = is_fp ? fp_tab[reg_no] : int_tab[reg_no];
      hit    = s.hit;
      idx    = s.hit ? s.target : reg_no;
      is_vec = s.hit & s.is_vec;
      width  = s.hit ? s.width : '0;
      simd   = s.hit & s.simd;
      bank   = s.hit & s.bank;
   end
endmodule

// File: rtl/regredir_table.sv
`timescale 1ns/1ps
module regredir_table
   import regredir_pkg::*;
#(
   parameter int N_ENT   = 16,
   parameter int N_PORTS = 2,
   parameter bit LATER_WINS = 1'b1,
   localparam int N_REG = 1 << REG_W,
   localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic [WORD_W-1:0]        cfg_word,
   input  logic [N_PORTS*REG_W-1:0] lk_reg,
   input  logic [N_PORTS-1:0]       lk_is_fp,
   output logic [N_PORTS-1:0]       lk_hit,
   output logic [N_PORTS*REG_W-1:0] lk_idx,
   output logic [N_PORTS-1:0]       lk_vec,
   output logic [N_PORTS*WID_W-1:0] lk_width,
   output logic [N_PORTS-1:0]       lk_simd,
   output logic [N_PORTS-1:0]       lk_bank
);
   if (N_ENT < 1 || N_ENT > 64) begin : g_bad_ent
      $error("regredir_table: N_ENT must lie in 1..64");
   end
   if (N_PORTS < 1 || N_PORTS > 8) begin : g_bad_ports
      $error("regredir_table: N_PORTS must lie in 1..8");
   end
   if ($bits(cfg_word_t) != WORD_W) begin : g_bad_word
      $error("regredir_table: word layout does not fill WORD_W");
   end

   cfg_word_t        words [N_ENT];
   logic [N_ENT-1:0] valid;
   slot_t            int_tab [N_REG];
   slot_t            fp_tab  [N_REG];

   regredir_cfg_store #(.N_ENT(N_ENT)) i_store (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_word), .words(words), .valid(valid)
   );

   regredir_shadow_build #(.N_ENT(N_ENT), .N_REG(N_REG), .LATER_WINS(LATER_WINS)) i_build (
      .clk(clk), .rst_n(rst_n), .words(words), .valid(valid),
      .int_tab(int_tab), .fp_tab(fp_tab)
   );

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      regredir_lookup_port #(.N_REG(N_REG)) i_port (
         .reg_no (lk_reg[p*REG_W +: REG_W]),
         .is_fp  (lk_is_fp[p]),
         .int_tab(int_tab),
         .fp_tab (fp_tab),
         .hit    (lk_hit[p]),
         .idx    (lk_idx[p*REG_W +: REG_W]),
         .is_vec (lk_vec[p]),
         .width  (lk_width[p*WID_W +: WID_W]),
         .simd   (lk_simd[p]),
         .bank   (lk_bank[p])
      );
   end

   if (N_PORTS > 1) begin : g_agree
      // R8: two ports asking the same question give the same answer
      a_r8_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
         ((lk_reg[REG_W-1:0] == lk_reg[2*REG_W-1:REG_W]) && (lk_is_fp[0] == lk_is_fp[1]))
         |-> ((lk_hit[0] == lk_hit[1]) &&
              (lk_idx[REG_W-1:0] == lk_idx[2*REG_W-1:REG_W]) &&
              (lk_width[WID_W-1:0] == lk_width[2*WID_W-1:WID_W]) &&
              (lk_vec[0] == lk_vec[1]) && (lk_simd[0] == lk_simd[1]) &&
              (lk_bank[0] == lk_bank[1])));
   end
endmodule

// File: tb/test_regredir_table.sv
`timescale 1ns/1ps
module test_regredir_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [15:0] cfg_word = '0;
   logic [9:0]  lk_reg = '0;
   logic [1:0]  lk_is_fp = '0;
   logic [1:0]  lk_hit, lk_vec, lk_simd, lk_bank;
   logic [9:0]  lk_idx;
   logic [3:0]  lk_width;

   always #2.5 clk = ~clk;

   regredir_table i_regredir_table (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
      .lk_reg(lk_reg), .lk_is_fp(lk_is_fp), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_vec(lk_vec), .lk_width(lk_width), .lk_simd(lk_simd), .lk_bank(lk_bank)
   );

   int n_run = 0, n_fail = 0;

   // Bench-side model: written words, and the copy visible to lookups.
   logic [15:0] m_word [16];
   logic        m_val  [16];
   logic [15:0] v_word [16];
   logic        v_val  [16];

   typedef struct { string tag; logic [10:0] exp0; logic [10:0] exp1; } item_t;
   item_t sb_q [$];

   // {hit, idx[4:0], vec, width[1:0], simd, bank}
   function automatic logic [10:0] expect_of(input logic [4:0] r, input logic fp);
      logic [10:0] e;
      e = {1'b0, r, 5'b0};
      for (int k = 0; k < 16; k++)
         if (v_val[k] && v_word[k][10] == fp && v_word[k][4:0] == r)
            e = {1'b1, v_word[k][9:5], v_word[k][13], v_word[k][12:11], v_word[k][15], v_word[k][14]};
      return e;
   endfunction

   function automatic logic [15:0] mk(input logic simd, input logic bank, input logic vec,
                                      input logic [1:0] w, input logic fp,
                                      input logic [4:0] tgt, input logic [4:0] key);
      return {simd, bank, vec, w, fp, tgt, key};
   endfunction

   task automatic commit();
      for (int k = 0; k < 16; k++) begin v_word[k] = m_word[k]; v_val[k] = m_val[k]; end
   endtask

   task automatic write_raw(input logic [3:0] sel, input logic [15:0] w);
      cfg_we = 1'b1; cfg_sel = sel; cfg_word = w;
      m_word[sel] = w; m_val[sel] = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic write_entry(input logic [3:0] sel, input logic [15:0] w);
      write_raw(sel, w);
      @(posedge clk); #1;
      commit();
   endtask

   task automatic lookup(input string tag, input logic [4:0] r0, input logic f0,
                         input logic [4:0] r1, input logic f1);
      item_t it;
      lk_reg = {r1, r0}; lk_is_fp = {f1, f0};
      it.tag = tag; it.exp0 = expect_of(r0, f0); it.exp1 = expect_of(r1, f1);
      sb_q.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int k = 0; k < 16; k++) begin m_val[k] = 1'b0; m_word[k] = '0; end
      commit();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // Monitor: compares both ports at the falling edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         logic [10:0] a0, a1;
         it = sb_q.pop_front();
         a0 = {lk_hit[0], lk_idx[4:0], lk_vec[0], lk_width[1:0], lk_simd[0], lk_bank[0]};
         a1 = {lk_hit[1], lk_idx[9:5], lk_vec[1], lk_width[3:2], lk_simd[1], lk_bank[1]};
         n_run += 2;
         if (a0 !== it.exp0) begin
            n_fail++;
            $display("FAIL %s port0 actual=%b expected=%b", it.tag, a0, it.exp0);
         end
         if (a1 !== it.exp1) begin
            n_fail++;
            $display("FAIL %s port1 actual=%b expected=%b", it.tag, a1, it.exp1);
         end
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: nothing hits after reset, register numbers pass through
      lookup("R1", 5'd3, 1'b0, 5'd7, 1'b1);
      lookup("R1", 5'd0, 1'b1, 5'd31, 1'b0);

      // R2: fields of a written word come back on a hit
      write_entry(4'd0, mk(1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 5'd20, 5'd3));
      lookup("R2", 5'd3, 1'b0, 5'd4, 1'b0);
      // R3: integer word does not hit a floating-point lookup of the same key
      lookup("R3", 5'd3, 1'b1, 5'd3, 1'b0);

      write_entry(4'd1, mk(1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 5'd9, 5'd3));
      // R8: both tables read in one cycle through separate ports
      lookup("R8", 5'd3, 1'b0, 5'd3, 1'b1);
      lookup("R3", 5'd3, 1'b1, 5'd9, 1'b1);

      // R5: higher entry wins, written before and after a lower one
      write_entry(4'd5, mk(1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 5'd30, 5'd3));
      lookup("R5", 5'd3, 1'b0, 5'd3, 1'b1);
      write_entry(4'd2, mk(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 5'd11, 5'd3));
      lookup("R5", 5'd3, 1'b0, 5'd30, 1'b0);

      // R6: re-keying entry 5 exposes entry 2 for key 3
      write_entry(4'd5, mk(1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 5'd17, 5'd8));
      lookup("R6", 5'd3, 1'b0, 5'd8, 1'b0);
      write_entry(4'd2, mk(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 5'd1, 5'd22));
      lookup("R6", 5'd3, 1'b0, 5'd22, 1'b1);

      // R2: last entry and key extremes
      write_entry(4'd15, mk(1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 5'd31, 5'd0));
      write_entry(4'd14, mk(1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 5'd0, 5'd31));
      lookup("R2", 5'd0, 1'b0, 5'd31, 1'b1);

      // R7: one cycle after the strobe the old mapping is still seen
      write_raw(4'd7, mk(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 5'd25, 5'd12));
      lookup("R7", 5'd12, 1'b1, 5'd12, 1'b0);
      commit();
      lookup("R7", 5'd12, 1'b1, 5'd12, 1'b0);

      // R4: misses keep their number, in both tables
      lookup("R4", 5'd29, 1'b0, 5'd13, 1'b1);
      lookup("R4", 5'd12, 1'b0, 5'd0, 1'b1);

      // R9: a second reset drops every mapping
      do_reset();
      lookup("R9", 5'd3, 1'b0, 5'd3, 1'b1);
      lookup("R9", 5'd0, 1'b0, 5'd12, 1'b1);

      @(posedge clk); #1;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule